// File: doc/BRIEF.md
# RTC Alarm Flag and Shared Interrupt Pin Logic

This block keeps the control and status bits that tie two alarm-match events and an oscillator-halt event to a single output pin. The pin is shared between two uses. In one mode it passes an externally generated square wave straight through. In the other mode it acts as an active-low interrupt request, raised by the alarm flags that are enabled.

The alarm flags and the oscillator-halt flag are sticky. A flag is set by its hardware event and stays set until software writes a 0 to it. A write of 1 never sets a flag. Time counting, alarm comparison, square-wave rate generation and the serial bus all sit outside the block. The match pulses and the square wave come in as plain inputs.

Software reaches the block through a one-cycle write strobe with a byte-select input. Both bytes are visible at all times on output ports.

Top module: `rtc_alarm_irq`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), ctrl_o is 3'b000 and status_o is 8'h80. After reset, and before any write, the pin follows sq_wave_i.
- R2: status_o bits 6 down to 2 always read 0. Bit 7 is the oscillator-halt flag, bit 1 is the alarm-2 flag and bit 0 is the alarm-1 flag.
- R3: A match pulse sampled high on a clock edge sets that alarm's flag from the next cycle, whatever the enable bits hold.
- R4: A status write (reg_we_i=1, reg_sel_i=1) clears each alarm flag whose data bit (bit 0 or bit 1) is 0. A data bit of 1 leaves that flag unchanged.
- R5: If a match pulse and a write of 0 to the same alarm flag fall on the same edge, the flag ends up at 1.
- R6: The oscillator-halt flag is set on the edge after osc_halt_i rises from 0 to 1. Holding osc_halt_i high does not set it again once it has been cleared.
- R7: A status write with data bit 7 at 0 clears the oscillator-halt flag. A data bit 7 of 1 never sets it.
- R8: A control write (reg_we_i=1, reg_sel_i=0) loads data bits 2..0 into ctrl_o: bit 2 is the interrupt-mode select, bit 1 is the alarm-2 enable and bit 0 is the alarm-1 enable. Data bits 7..3 are ignored, and status writes leave ctrl_o unchanged.
- R9: With ctrl_o[2]=1, irq_pin_n_o is 0 exactly when (alarm-1 flag AND ctrl_o[0]) OR (alarm-2 flag AND ctrl_o[1]). Otherwise it is 1, and sq_wave_i has no effect on it.
- R10: With ctrl_o[2]=0, irq_pin_n_o equals sq_wave_i and the flags have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| match_a1_i | input | 1 | Alarm-1 match pulse |
| match_a2_i | input | 1 | Alarm-2 match pulse |
| osc_halt_i | input | 1 | High while the oscillator is stopped or disabled |
| sq_wave_i | input | 1 | Square wave to pass to the pin |
| reg_we_i | input | 1 | Register write strobe, one cycle |
| reg_sel_i | input | 1 | Byte select: 0 control, 1 status |
| reg_wdata_i | input | 8 | Write data |
| ctrl_o | output | 3 | Control bits {mode, alarm-2 enable, alarm-1 enable} |
| status_o | output | 8 | Status byte |
| irq_pin_n_o | output | 1 | Shared pin level, 0 = driven low, 1 = released |

## Verification
The checker watches several rules on every cycle. It confirms that the reserved status bits are zero. It confirms that a match is always followed by its flag, and that a flag rises only after its own event. It confirms that the control bits move only on control writes, and that the pin matches the mode rule. Whether a write of 1 really leaves a flag untouched, the outcome when a set and a clear collide, and the fact that the halt flag responds to an edge rather than a level are shown by the bench's directed scenarios, each of which carries flags through a known sequence of writes and events.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int N_ALARM  = 2;
  localparam int STAT_W   = 8;
  localparam int CTRL_W   = N_ALARM + 1;
  localparam int HALT_BIT = STAT_W - 1;
  localparam int MODE_BIT = N_ALARM;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_t;

  // sticky bit update: a hardware set outranks a software clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  // any enabled flag requests service
  function automatic logic irq_request(input logic [N_ALARM-1:0] flags,
                                       input logic [N_ALARM-1:0] enables);
    return |(flags & enables);
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic halt_flag,
                                                     input logic [N_ALARM-1:0] flags);
    logic [STAT_W-1:0] s;
    s = '0;
    s[HALT_BIT] = halt_flag;
    s[N_ALARM-1:0] = flags;
    return s;
  endfunction
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_irq_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags
  import rtc_irq_pkg::*;
#(
  parameter int N = N_ALARM
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] match_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o[i] <= 1'b0;
      else        flag_o[i] <= sticky_next(flag_o[i], match_i[i], clr_i[i]);
    end
  end
endmodule

// File: rtl/rtc_osc_watch.sv
module rtc_osc_watch
  import rtc_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  logic clr_i,
  output logic flag_o,
  output logic rise_o
);
  logic halt_q;

  assign rise_o = halt_i & ~halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      flag_o <= 1'b1;
    end else begin
      halt_q <= halt_i;
      flag_o <= sticky_next(flag_o, rise_o, clr_i);
    end
  end
endmodule

// File: rtl/rtc_pin_mux.sv
module rtc_pin_mux
  import rtc_irq_pkg::*;
#(
  parameter int N = N_ALARM
) (
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  input  logic         irq_mode_i,
  input  logic         sq_wave_i,
  output logic         irq_req_o,
  output logic         pin_n_o
);
  assign irq_req_o = irq_request(flag_i, en_i);
  assign pin_n_o   = irq_mode_i ? ~irq_req_o : sq_wave_i;
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match_a1_i,
  input  logic              match_a2_i,
  input  logic              osc_halt_i,
  input  logic              sq_wave_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_pin_n_o
);
  logic               ctrl_we, stat_we;
  logic [N_ALARM-1:0] match_vec, clr_vec, alarm_flags;
  logic               halt_flag, halt_rise, irq_req;
  logic               unused_rsvd;

  assign ctrl_we   = reg_we_i && (reg_sel_t'(reg_sel_i) == SEL_CTRL);
  assign stat_we   = reg_we_i && (reg_sel_t'(reg_sel_i) == SEL_STAT);
  assign match_vec = {match_a2_i, match_a1_i};
  assign clr_vec   = {N_ALARM{stat_we}} & ~reg_wdata_i[N_ALARM-1:0];
  assign unused_rsvd = ^reg_wdata_i[HALT_BIT-1:CTRL_W];

  rtc_ctrl_reg #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we_i(ctrl_we),
    .d_i(reg_wdata_i[CTRL_W-1:0]), .q_o(ctrl_o)
  );

  rtc_alarm_flags #(.N(N_ALARM)) u_flags (
    .clk(clk), .rst_n(rst_n), .match_i(match_vec),
    .clr_i(clr_vec), .flag_o(alarm_flags)
  );

  rtc_osc_watch u_osc (
    .clk(clk), .rst_n(rst_n), .halt_i(osc_halt_i),
    .clr_i(stat_we & ~reg_wdata_i[HALT_BIT]),
    .flag_o(halt_flag), .rise_o(halt_rise)
  );

  rtc_pin_mux #(.N(N_ALARM)) u_pin (
    .flag_i(alarm_flags), .en_i(ctrl_o[N_ALARM-1:0]),
    .irq_mode_i(ctrl_o[MODE_BIT]), .sq_wave_i(sq_wave_i),
    .irq_req_o(irq_req), .pin_n_o(irq_pin_n_o)
  );

  assign status_o = pack_status(halt_flag, alarm_flags);
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk
  import rtc_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              match_a1_i,
  input logic              match_a2_i,
  input logic              sq_wave_i,
  input logic              reg_we_i,
  input logic              reg_sel_i,
  input logic              halt_rise,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [STAT_W-1:0] status_o,
  input logic              irq_pin_n_o
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[HALT_BIT-1:N_ALARM] == '0);

  p_a1_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_a1_i |=> status_o[0]);

  p_a2_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_a2_i |=> status_o[1]);

  p_a1_only_by_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> $past(match_a1_i));

  p_a2_only_by_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[1]) |-> $past(match_a2_i));

  p_halt_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_rise |=> status_o[HALT_BIT]);

  p_halt_no_sw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[HALT_BIT]) |-> $past(halt_rise));

  p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_i && !reg_sel_i) |=> $stable(ctrl_o));

  p_pin_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[MODE_BIT] |-> (irq_pin_n_o ==
      !((status_o[0] && ctrl_o[0]) || (status_o[1] && ctrl_o[1]))));

  p_pin_sqw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_o[MODE_BIT] |-> (irq_pin_n_o == sq_wave_i));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .match_a1_i(match_a1_i), .match_a2_i(match_a2_i),
  .sq_wave_i(sq_wave_i), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
  .halt_rise(halt_rise), .ctrl_o(ctrl_o), .status_o(status_o),
  .irq_pin_n_o(irq_pin_n_o)
);

// File: tb/sim_rtc_alarm_irq.sv
module sim_rtc_alarm_irq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       match_a1_i = 1'b0, match_a2_i = 1'b0, osc_halt_i = 1'b0, sq_wave_i = 1'b0;
  logic       reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [2:0] ctrl_o;
  logic [7:0] status_o;
  logic       irq_pin_n_o;
  int         total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_irq u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench's own pin rule
  function automatic logic exp_pin(input logic [2:0] c, input logic [7:0] s, input logic sq);
    if (!c[2]) return sq;
    return ((s[0] & c[0]) | (s[1] & c[1])) ? 1'b0 : 1'b1;
  endfunction

  // drive on a falling edge, hold across one rising edge, release
  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk); reg_we_i = 1'b0; reg_wdata_i = 8'h00;
  endtask

  task automatic hit(input logic a1, input logic a2);
    @(negedge clk); match_a1_i = a1; match_a2_i = a2;
    @(negedge clk); match_a1_i = 1'b0; match_a2_i = 1'b0;
  endtask

  task automatic t_reset;
    #(CLK_PERIOD*2);
    chk("R1 ctrl in reset", {5'b0, ctrl_o}, 8'h00);
    chk("R1 status in reset", status_o, 8'h80);
    @(negedge clk); rst_n = 1'b1;
    sq_wave_i = 1'b1; #1 chk("R1 pin follows sqw hi", {7'b0, irq_pin_n_o}, 8'h01);
    sq_wave_i = 1'b0; #1 chk("R1 pin follows sqw lo", {7'b0, irq_pin_n_o}, 8'h00);
  endtask

  task automatic t_alarm_set;
    wr(1'b1, 8'h00);
    chk("R7 halt flag cleared", status_o, 8'h00);
    hit(1'b1, 1'b0);
    chk("R3 a1 set without enable", status_o, 8'h01);
    hit(1'b0, 1'b1);
    chk("R3 a2 set without enable", status_o, 8'h03);
    chk("R2 reserved bits zero", status_o & 8'h7C, 8'h00);
  endtask

  task automatic t_clear_rules;
    wr(1'b1, 8'hFE);
    chk("R4 clear a1 keep a2", status_o, 8'h02);
    wr(1'b1, 8'hFF);
    chk("R4 write ones no change", status_o, 8'h02);
    wr(1'b1, 8'h01);
    chk("R4 clear a2, one on a1 no set", status_o, 8'h00);
  endtask

  task automatic t_collision;
    hit(1'b0, 1'b1);
    @(negedge clk); reg_we_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 8'h00; match_a1_i = 1'b1;
    @(negedge clk); reg_we_i = 1'b0; match_a1_i = 1'b0;
    chk("R5 set beats clear", status_o, 8'h01);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_osc;
    @(negedge clk); osc_halt_i = 1'b1;
    @(negedge clk);
    chk("R6 halt rise sets flag", status_o, 8'h80);
    wr(1'b1, 8'h00);
    repeat (3) @(negedge clk);
    chk("R6 held level no re-set", status_o, 8'h00);
    wr(1'b1, 8'hFF);
    chk("R7 write one no set", status_o, 8'h00);
    @(negedge clk); osc_halt_i = 1'b0;
    @(negedge clk); osc_halt_i = 1'b1;
    @(negedge clk);
    chk("R6 second rise sets", status_o, 8'h80);
    osc_halt_i = 1'b0;
    wr(1'b1, 8'h7F);
    chk("R7 clear by zero", status_o, 8'h00);
  endtask

  task automatic t_ctrl;
    wr(1'b0, 8'hF8);
    chk("R8 upper bits ignored", {5'b0, ctrl_o}, 8'h00);
    wr(1'b0, 8'h05);
    chk("R8 load mode+a1en", {5'b0, ctrl_o}, 8'h05);
    wr(1'b1, 8'h02);
    chk("R8 status write keeps ctrl", {5'b0, ctrl_o}, 8'h05);
  endtask

  task automatic t_irq_mode;
    sq_wave_i = 1'b0; #1
    chk("R9 no flags released", {7'b0, irq_pin_n_o}, 8'h01);
    hit(1'b0, 1'b1);
    chk("R9 a2 disabled released", {7'b0, irq_pin_n_o}, {7'b0, exp_pin(3'b101, 8'h02, 1'b0)});
    hit(1'b1, 1'b0);
    chk("R9 a1 enabled low", {7'b0, irq_pin_n_o}, 8'h00);
    sq_wave_i = 1'b1; #1
    chk("R9 sqw ignored", {7'b0, irq_pin_n_o}, 8'h00);
    wr(1'b1, 8'hFE);
    chk("R9 released after clear", {7'b0, irq_pin_n_o}, 8'h01);
    wr(1'b0, 8'h06);
    chk("R9 a2 enabled low", {7'b0, irq_pin_n_o}, 8'h00);
  endtask

  task automatic t_sqw_mode;
    wr(1'b0, 8'h03);
    hit(1'b1, 1'b1);
    sq_wave_i = 1'b1; #1
    chk("R10 pin follows sqw hi", {7'b0, irq_pin_n_o}, 8'h01);
    sq_wave_i = 1'b0; #1
    chk("R10 pin follows sqw lo", {7'b0, irq_pin_n_o}, 8'h00);
    chk("R2 reserved zero at end", status_o & 8'h7C, 8'h00);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD*5000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_alarm_set();
    t_clear_rules();
    t_collision();
    t_osc();
    t_ctrl();
    t_irq_mode();
    t_sqw_mode();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule